// File: doc/BRIEF.md
# Configuration Frame Scrub Controller

This block walks a range of configuration frames over and over, without stopping between passes. Each frame is held in a frame memory as a number of data words plus one trailing check word. The controller reads every word of a frame through a simple read/write memory port, decodes the check word to find a bad bit, and writes the corrected frame back when one data bit has flipped. Errors that it cannot correct are not fixed here. They go out as event reports so that an outer repair agent can rewrite the frame.

At the end of each pass, a CRC-32 taken over the corrected data words of every frame in the range is compared with a golden value. A mismatch raises a full-reconfiguration request. A policy input selects what happens on a single-bit error: report and stop, repair and stop, or repair and keep going. Every uncorrectable frame stops the sweep until a resume pulse arrives. The sweep range is given by first and last frame inputs, so a region whose contents are protected by other means is simply left outside it.

Top module: `frame_scrub_ctrl`

## Requirements
- R1: Frames are read in order from `first_frame_i` to `last_frame_i`, words 0 to WORDS within each frame (word WORDS is the check word), then the sweep wraps to `first_frame_i`. No read or write ever addresses a frame outside the range. Read data is taken from `mem_rdata_i` one cycle after `mem_rd_o`.
- R2: The check word carries, in its low CW=$clog2(WORDS*DW+1) bits, the XOR of (g+1) over every set data bit g = word*DW + bit, and in bit DW-1 the parity of all data bits. A parity mismatch with a nonzero in-range syndrome S is a single-bit error at g = S-1. Any other nonzero result, including a parity mismatch with S = 0, is uncorrectable.
- R3: A repair writes the WORDS data words of the frame back, with the located bit inverted. The check word is never written.
- R4: An event carries a kind (0 repaired single, 1 single found but not repaired, 2 uncorrectable frame, 3 pass CRC mismatch), a frame number, a word number and a bit number. Kinds 2 and 3 report word 0 and bit 0.
- R5: With `mode_i`=0, a single-bit error is reported as kind 1, nothing is written, and the controller halts.
- R6: With `mode_i`=1, a single-bit error is repaired, reported as kind 0, and the controller then halts.
- R7: With `mode_i`=2 or 3, a single-bit error is repaired, reported as kind 0, and the sweep carries on without halting.
- R8: An uncorrectable frame is reported as kind 2 with its frame number, no write is made, and the controller halts in every mode.
- R9: While halted, `halted_o` is high and the memory port is idle. A one-cycle `resume_i` releases the halt, and the first read after that is word 0 of the frame that caused the halt.
- R10: The CRC is CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF, data bits taken MSB first, with no reflection and no final inversion. It runs over the corrected data words of each frame in sweep order, check words excluded, and is compared with `golden_crc_i` once per pass after the last frame. A mismatch is reported as kind 3 with the last frame number, and the sweep restarts without halting.
- R11: `reconfig_req_o` rises together with a kind 3 report and stays high until a later pass compares equal.
- R12: While `ev_valid_o` is high and `ev_ready_i` is low, the report fields hold steady and the memory port stays idle.
- R13: After reset, `ev_valid_o`, `halted_o`, `reconfig_req_o`, `mem_rd_o` and `mem_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Single-error policy: 0 report and stop, 1 repair and stop, 2/3 repair and continue |
| first_frame_i | input | FW | First frame of the sweep range |
| last_frame_i | input | FW | Last frame of the sweep range |
| golden_crc_i | input | 32 | Expected CRC of one pass |
| resume_i | input | 1 | Releases a halt |
| mem_rd_o | output | 1 | Frame memory read strobe |
| mem_wr_o | output | 1 | Frame memory write strobe |
| mem_frame_o | output | FW | Frame address |
| mem_word_o | output | AW | Word address within frame |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after the strobe |
| ev_valid_o | output | 1 | Event report valid |
| ev_ready_i | input | 1 | Event report accepted |
| ev_kind_o | output | 2 | Event kind |
| ev_frame_o | output | FW | Frame of the event |
| ev_word_o | output | AW | Word of the located bit |
| ev_bit_o | output | BW | Bit of the located bit |
| halted_o | output | 1 | Controller is stopped awaiting resume |
| reconfig_req_o | output | 1 | Full reconfiguration requested |

## Verification
The repair of a single-bit error in the last frame of the range and the end-of-pass CRC comparison fall in the same stretch of cycles, because the comparison must take the freshly corrected words. The bench provokes this by planting an error in the last frame while the controller is halted and, in one run, also loading a wrong golden value. With a correct golden value, a single repair report must appear and no reconfiguration request. With a wrong one, the repair report must come first and the CRC report second.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

   typedef enum logic [1:0] {
      EV_FIXED = 2'd0,
      EV_FOUND = 2'd1,
      EV_MULTI = 2'd2,
      EV_CRC   = 2'd3
   } ev_kind_t;

   typedef enum logic [3:0] {
      S_START, S_READ, S_RWAIT, S_CHECK, S_WRITE,
      S_REPORT, S_FOLD, S_CRC, S_HALT
   } scrub_state_t;

   typedef enum logic [1:0] {
      POST_HALT, POST_FOLD, POST_PASS
   } post_act_t;

   localparam logic [1:0]  MODE_DETECT   = 2'd0;
   localparam logic [1:0]  MODE_FIX_STOP = 2'd1;
   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

endpackage

// File: rtl/scrub_crc_step.sv
module scrub_crc_step #(
   parameter int          DW   = 32,
   parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
   input  logic [31:0]   crc_i,
   input  logic [DW-1:0] data_i,
   output logic [31:0]   crc_o
);

   if (DW < 1) begin : g_bad_dw
      $error("scrub_crc_step: DW must be at least 1");
   end

   logic [31:0] acc;

   always_comb begin
      acc = crc_i;
      for (int i = DW - 1; i >= 0; i--) begin
         if (acc[31] ^ data_i[i]) acc = (acc << 1) ^ POLY;
         else                     acc = acc << 1;
      end
      crc_o = acc;
   end

endmodule

// File: rtl/scrub_frame_ecc.sv
module scrub_frame_ecc #(
   parameter int WORDS = 4,
   parameter int DW    = 32,
   parameter int AW    = $clog2(WORDS + 1),
   parameter int BW    = $clog2(DW)
) (
   input  logic [WORDS*DW-1:0] data_i,
   input  logic [DW-1:0]       chk_i,
   output logic                single_o,
   output logic                multi_o,
   output logic [AW-1:0]       word_o,
   output logic [BW-1:0]       bit_o
);

   localparam int NB = WORDS * DW;
   localparam int CW = $clog2(NB + 1);

   if (CW >= DW) begin : g_bad_code
      $error("scrub_frame_ecc: syndrome does not fit below the parity bit");
   end
   if (DW < 2) begin : g_bad_dw
      $error("scrub_frame_ecc: DW must be at least 2");
   end

   logic [CW-1:0] code_calc, syn, loc;
   logic          par, pmis;

   always_comb begin
      code_calc = '0;
      par       = 1'b0;
      for (int g = 0; g < NB; g++) begin
         if (data_i[g]) begin
            code_calc = code_calc ^ CW'(g + 1);
            par       = ~par;
         end
      end
   end

   assign syn      = code_calc ^ chk_i[CW-1:0];
   assign pmis     = par ^ chk_i[DW-1];
   assign single_o = pmis && (syn != '0) && (int'(syn) <= NB);
   assign multi_o  = ((syn != '0) || pmis) && !single_o;
   assign loc      = syn - CW'(1);

   if ((DW & (DW - 1)) == 0) begin : g_pow2
      assign word_o = AW'(loc >> BW);
      assign bit_o  = loc[BW-1:0];
   end else begin : g_div
      assign word_o = AW'(loc / CW'(DW));
      assign bit_o  = BW'(loc % CW'(DW));
   end

endmodule

// File: rtl/frame_scrub_ctrl.sv
module frame_scrub_ctrl
   import scrub_pkg::*;
#(
   parameter int          FW    = 4,
   parameter int          WORDS = 4,
   parameter int          DW    = 32,
   parameter logic [31:0] POLY  = 32'h04C1_1DB7,
   parameter int          AW    = $clog2(WORDS + 1),
   parameter int          BW    = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic [FW-1:0] first_frame_i,
   input  logic [FW-1:0] last_frame_i,
   input  logic [31:0]   golden_crc_i,
   input  logic          resume_i,
   output logic          mem_rd_o,
   output logic          mem_wr_o,
   output logic [FW-1:0] mem_frame_o,
   output logic [AW-1:0] mem_word_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          ev_valid_o,
   input  logic          ev_ready_i,
   output logic [1:0]    ev_kind_o,
   output logic [FW-1:0] ev_frame_o,
   output logic [AW-1:0] ev_word_o,
   output logic [BW-1:0] ev_bit_o,
   output logic          halted_o,
   output logic          reconfig_req_o
);

   localparam logic [AW-1:0] LAST_IDX = AW'(WORDS);
   localparam logic [AW-1:0] LAST_DAT = AW'(WORDS - 1);

   if (WORDS < 1) begin : g_bad_words
      $error("frame_scrub_ctrl: WORDS must be at least 1");
   end
   if (FW < 1) begin : g_bad_fw
      $error("frame_scrub_ctrl: FW must be at least 1");
   end

   scrub_state_t  state;
   post_act_t     post_q;
   logic [FW-1:0] frame_q;
   logic [AW-1:0] cnt, pidx;
   logic          pv;
   logic [31:0]   crc_q, crc_next;
   logic [1:0]    mode_q;
   ev_kind_t      ev_kind_q;
   logic [DW-1:0] fbuf [0:WORDS];
   logic [WORDS*DW-1:0] flat;
   logic          ecc_single, ecc_multi;
   logic [AW-1:0] ecc_word;
   logic [BW-1:0] ecc_bit;
   logic          do_fix;

   always_comb begin
      for (int w = 0; w < WORDS; w++) flat[w*DW +: DW] = fbuf[w];
   end

   scrub_frame_ecc #(.WORDS(WORDS), .DW(DW), .AW(AW), .BW(BW)) u_ecc (
      .data_i  (flat),
      .chk_i   (fbuf[WORDS]),
      .single_o(ecc_single),
      .multi_o (ecc_multi),
      .word_o  (ecc_word),
      .bit_o   (ecc_bit)
   );

   scrub_crc_step #(.DW(DW), .POLY(POLY)) u_crc (
      .crc_i (crc_q),
      .data_i(fbuf[cnt]),
      .crc_o (crc_next)
   );

   assign do_fix = (state == S_CHECK) && !ecc_multi && ecc_single && (mode_q != MODE_DETECT);

   // frame buffer: filled from read data, one located bit flipped on repair
   always_ff @(posedge clk) begin
      if (pv)          fbuf[pidx] <= mem_rdata_i;
      else if (do_fix) fbuf[ecc_word][ecc_bit] <= ~fbuf[ecc_word][ecc_bit];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= S_START;
         post_q         <= POST_FOLD;
         frame_q        <= '0;
         cnt            <= '0;
         pidx           <= '0;
         pv             <= 1'b0;
         crc_q          <= CRC_SEED;
         mode_q         <= MODE_DETECT;
         ev_valid_o     <= 1'b0;
         ev_kind_q      <= EV_FIXED;
         ev_frame_o     <= '0;
         ev_word_o      <= '0;
         ev_bit_o       <= '0;
         reconfig_req_o <= 1'b0;
      end else begin
         pv   <= (state == S_READ);
         pidx <= cnt;
         unique case (state)
            S_START: begin
               frame_q <= first_frame_i;
               crc_q   <= CRC_SEED;
               cnt     <= '0;
               state   <= S_READ;
            end
            S_READ: begin
               mode_q <= mode_i;
               cnt    <= cnt + AW'(1);
               if (cnt == LAST_IDX) state <= S_RWAIT;
            end
            S_RWAIT: begin
               cnt   <= '0;
               state <= S_CHECK;
            end
            S_CHECK: begin
               ev_frame_o <= frame_q;
               if (ecc_multi) begin
                  ev_kind_q  <= EV_MULTI;
                  ev_word_o  <= '0;
                  ev_bit_o   <= '0;
                  ev_valid_o <= 1'b1;
                  post_q     <= POST_HALT;
                  state      <= S_REPORT;
               end else if (ecc_single) begin
                  ev_word_o <= ecc_word;
                  ev_bit_o  <= ecc_bit;
                  if (mode_q == MODE_DETECT) begin
                     ev_kind_q  <= EV_FOUND;
                     ev_valid_o <= 1'b1;
                     post_q     <= POST_HALT;
                     state      <= S_REPORT;
                  end else begin
                     ev_kind_q <= EV_FIXED;
                     state     <= S_WRITE;
                  end
               end else begin
                  state <= S_FOLD;
               end
            end
            S_WRITE: begin
               cnt <= cnt + AW'(1);
               if (cnt == LAST_DAT) begin
                  cnt        <= '0;
                  ev_valid_o <= 1'b1;
                  post_q     <= (mode_q == MODE_FIX_STOP) ? POST_HALT : POST_FOLD;
                  state      <= S_REPORT;
               end
            end
            S_REPORT: begin
               if (ev_ready_i) begin
                  ev_valid_o <= 1'b0;
                  cnt        <= '0;
                  unique case (post_q)
                     POST_HALT: state <= S_HALT;
                     POST_FOLD: state <= S_FOLD;
                     default: begin
                        frame_q <= first_frame_i;
                        crc_q   <= CRC_SEED;
                        state   <= S_READ;
                     end
                  endcase
               end
            end
            S_FOLD: begin
               crc_q <= crc_next;
               cnt   <= cnt + AW'(1);
               if (cnt == LAST_DAT) begin
                  cnt <= '0;
                  if (frame_q == last_frame_i) begin
                     state <= S_CRC;
                  end else begin
                     frame_q <= frame_q + FW'(1);
                     state   <= S_READ;
                  end
               end
            end
            S_CRC: begin
               cnt <= '0;
               if (crc_q != golden_crc_i) begin
                  reconfig_req_o <= 1'b1;
                  ev_kind_q      <= EV_CRC;
                  ev_frame_o     <= frame_q;
                  ev_word_o      <= '0;
                  ev_bit_o       <= '0;
                  ev_valid_o     <= 1'b1;
                  post_q         <= POST_PASS;
                  state          <= S_REPORT;
               end else begin
                  reconfig_req_o <= 1'b0;
                  frame_q        <= first_frame_i;
                  crc_q          <= CRC_SEED;
                  state          <= S_READ;
               end
            end
            S_HALT: begin
               if (resume_i) begin
                  cnt   <= '0;
                  state <= S_READ;
               end
            end
            default: state <= S_START;
         endcase
      end
   end

   assign ev_kind_o   = ev_kind_q;
   assign mem_rd_o    = (state == S_READ);
   assign mem_wr_o    = (state == S_WRITE);
   assign mem_frame_o = frame_q;
   assign mem_word_o  = cnt;
   assign mem_wdata_o = fbuf[cnt];
   assign halted_o    = (state == S_HALT);

   assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || mem_wr_o) |-> (mem_frame_o >= first_frame_i && mem_frame_o <= last_frame_i));

   assert_check_word_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_word_o < LAST_IDX));

   assert_detect_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mode_q != MODE_DETECT));

   assert_multi_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_o && ev_ready_i && ev_kind_o == EV_MULTI) |=> halted_o);

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && !resume_i) |=> halted_o);

   assert_reconfig_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reconfig_req_o) |-> (ev_valid_o && ev_kind_o == EV_CRC));

   assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_o && !ev_ready_i) |=> (ev_valid_o && $stable(ev_kind_o) && $stable(ev_frame_o)
                                       && $stable(ev_word_o) && $stable(ev_bit_o)));

   assert_port_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_o || halted_o) |-> !(mem_rd_o || mem_wr_o));

endmodule

// File: tb/sim_frame_scrub_ctrl.sv
module sim_frame_scrub_ctrl;

   localparam int FW = 4, WORDS = 4, DW = 32, AW = 3, BW = 5;
   localparam int F0 = 2, F1 = 5;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [1:0]    mode = 2'd2;
   logic [31:0]   golden = '0;
   logic          resume = 1'b0, ev_ready = 1'b1;
   logic          mem_rd, mem_wr, ev_valid, halted, reconfig;
   logic [FW-1:0] mem_frame, ev_frame;
   logic [AW-1:0] mem_word, ev_word;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic [1:0]    ev_kind;
   logic [BW-1:0] ev_bit;

   logic [31:0] clean [0:15][0:4];
   logic [31:0] mem   [0:15][0:4];
   logic        poke_en = 1'b0;
   int          poke_f = 0, poke_w = 0;
   logic [31:0] poke_d = '0;

   int vectors = 0, fails = 0, cyc = 0, ev_cnt = 0;
   bit chk_order = 1'b0;
   int ef = F0, ew = 0;

   always #4 clk = ~clk;

   frame_scrub_ctrl #(.FW(FW), .WORDS(WORDS), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .first_frame_i(4'(F0)), .last_frame_i(4'(F1)),
      .golden_crc_i(golden), .resume_i(resume),
      .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_frame_o(mem_frame),
      .mem_word_o(mem_word), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .ev_valid_o(ev_valid), .ev_ready_i(ev_ready), .ev_kind_o(ev_kind),
      .ev_frame_o(ev_frame), .ev_word_o(ev_word), .ev_bit_o(ev_bit),
      .halted_o(halted), .reconfig_req_o(reconfig)
   );

   // frame memory model: registered read, single writer block
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int f = 0; f < 16; f++)
            for (int w = 0; w < 5; w++) mem[f][w] <= clean[f][w];
      end else begin
         if (mem_rd) mem_rdata <= mem[mem_frame][mem_word];
         if (mem_wr) mem[mem_frame][mem_word] <= mem_wdata;
         if (poke_en) mem[poke_f][poke_w] <= poke_d;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] code_word(input int f);
      logic [7:0] code = '0;
      logic       par = 1'b0;
      for (int w = 0; w < WORDS; w++)
         for (int b = 0; b < DW; b++)
            if (clean[f][w][b]) begin
               code = code ^ 8'(w * DW + b + 1);
               par  = ~par;
            end
      return {par, 23'd0, code};
   endfunction

   function automatic logic [31:0] pass_crc();
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int f = F0; f <= F1; f++)
         for (int w = 0; w < WORDS; w++)
            for (int i = DW - 1; i >= 0; i--)
               c = (c[31] ^ clean[f][w][i]) ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
      return c;
   endfunction

   // monitor: range, check word writes, sweep order, accepted events
   always @(negedge clk) begin
      if (rst_n) begin
         if ((mem_rd || mem_wr) && (int'(mem_frame) < F0 || int'(mem_frame) > F1))
            chk(1'b0, "R1", "access outside range", 64'(mem_frame), 64'(F0));
         if (mem_wr && int'(mem_word) >= WORDS)
            chk(1'b0, "R3", "check word written", 64'(mem_word), 64'(WORDS - 1));
         if (chk_order && mem_rd) begin
            chk(int'(mem_frame) == ef && int'(mem_word) == ew, "R1", "sweep order",
                {32'(mem_frame), 32'(mem_word)}, {32'(ef), 32'(ew)});
            ew++;
            if (ew == WORDS + 1) begin
               ew = 0;
               ef = (ef == F1) ? F0 : ef + 1;
            end
         end
         if (ev_valid && ev_ready) ev_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic poke(input int f, input int w, input logic [31:0] d);
      @(negedge clk);
      poke_en = 1'b1; poke_f = f; poke_w = w; poke_d = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic flip(input int f, input int g);
      poke(f, g / DW, mem[f][g / DW] ^ (32'd1 << (g % DW)));
   endtask

   task automatic wait_ev(output int k, output int f, output int w, output int b);
      int n = 0;
      k = -1; f = -1; w = -1; b = -1;
      @(negedge clk);
      while (!ev_valid && n < 600) begin
         @(negedge clk);
         n++;
      end
      chk(ev_valid, "R4", "event timeout", 64'(n), 64'd600);
      k = int'(ev_kind); f = int'(ev_frame); w = int'(ev_word); b = int'(ev_bit);
      @(posedge clk);
   endtask

   task automatic wait_halted(input string req);
      int n = 0;
      @(negedge clk);
      while (!halted && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(halted, req, "halted", 64'(halted), 64'd1);
   endtask

   task automatic resume_chk(input int f, input string req);
      int n = 0;
      @(negedge clk);
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
      while (!mem_rd && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(int'(mem_frame) == f && mem_word == '0, req, "first read after resume",
          {32'(mem_frame), 32'(mem_word)}, {32'(f), 32'd0});
   endtask

   initial begin
      int k, f, w, b, g, n0, pf;
      bit ok;
      for (int fr = 0; fr < 16; fr++) begin
         for (int wd = 0; wd < WORDS; wd++)
            clean[fr][wd] = 32'h9E37_79B9 * 32'(fr * 8 + wd + 1) ^ 32'h5A5A_0F0F;
         clean[fr][WORDS] = code_word(fr);
      end
      golden = pass_crc();
      chk_order = 1'b1;

      // R13: reset state
      repeat (3) @(negedge clk);
      chk(!ev_valid && !halted && !reconfig && !mem_rd && !mem_wr, "R13", "outputs in reset",
          {59'd0, ev_valid, halted, reconfig, mem_rd, mem_wr}, 64'd0);
      rst_n = 1'b1;

      // R1/R10: two clean passes, strict order, no events
      repeat (100) @(negedge clk);
      chk_order = 1'b0;
      chk(ev_cnt == 0, "R10", "events on clean passes", 64'(ev_cnt), 64'd0);
      chk(!reconfig, "R10", "reconfig on clean passes", 64'(reconfig), 64'd0);

      // R10/R11: wrong golden value
      golden = ~pass_crc();
      wait_ev(k, f, w, b);
      golden = pass_crc();
      chk(k == 3 && f == F1 && w == 0 && b == 0, "R10", "crc event",
          {16'(k), 16'(f), 16'(w), 16'(b)}, {16'd3, 16'(F1), 32'd0});
      @(negedge clk);
      chk(reconfig, "R11", "reconfig raised", 64'(reconfig), 64'd1);
      repeat (100) @(negedge clk);
      chk(!reconfig, "R11", "reconfig cleared after good pass", 64'(reconfig), 64'd0);

      // R12: back-pressure holds report and stalls the sweep
      ev_ready = 1'b0;
      golden = ~pass_crc();
      n0 = 0;
      while (!ev_valid && n0 < 600) begin
         @(negedge clk);
         n0++;
      end
      f = int'(ev_frame);
      ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!ev_valid || int'(ev_frame) != f || ev_kind != 2'd3 || mem_rd || mem_wr) ok = 1'b0;
      end
      chk(ok, "R12", "stall with ready low", 64'(ev_valid), 64'd1);
      golden = pass_crc();
      ev_ready = 1'b1;
      repeat (120) @(negedge clk);
      chk(!reconfig, "R11", "reconfig cleared after stall", 64'(reconfig), 64'd0);

      // R2/R3/R4/R6/R9: every bit position repaired in repair-and-stop mode
      mode = 2'd1;
      pf = -1;
      for (int i = 0; i < WORDS * DW; i++) begin
         f = F0 + (i % 4);
         flip(f, i);
         if (pf >= 0) resume_chk(pf, "R9");
         wait_ev(k, g, w, b);
         chk(k == 0 && g == f && w == i / DW && b == i % DW, "R4", "repair event fields",
             {16'(k), 16'(g), 16'(w), 16'(b)}, {16'd0, 16'(f), 16'(i / DW), 16'(i % DW)});
         wait_halted("R6");
         chk(mem[f][i / DW] == clean[f][i / DW], "R3", "word repaired",
             64'(mem[f][i / DW]), 64'(clean[f][i / DW]));
         pf = f;
      end

      // R7: repair and continue
      mode = 2'd2;
      flip(3, 1 * DW + 5);
      resume_chk(pf, "R9");
      wait_ev(k, g, w, b);
      chk(k == 0 && g == 3 && w == 1 && b == 5, "R7", "continue-mode event",
          {16'(k), 16'(g), 16'(w), 16'(b)}, {16'd0, 16'd3, 16'd1, 16'd5});
      ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (halted) ok = 1'b0;
      end
      chk(ok, "R7", "no halt after repair", 64'(halted), 64'd0);
      chk(mem[3][1] == clean[3][1], "R7", "word repaired", 64'(mem[3][1]), 64'(clean[3][1]));

      // R10: top bit of the last frame repaired, CRC still matches
      flip(F1, WORDS * DW - 1);
      wait_ev(k, g, w, b);
      chk(k == 0 && g == F1 && w == WORDS - 1 && b == DW - 1, "R2", "highest syndrome",
          {16'(k), 16'(g), 16'(w), 16'(b)}, {16'd0, 16'(F1), 16'(WORDS - 1), 16'(DW - 1)});
      n0 = ev_cnt;
      repeat (120) @(negedge clk);
      chk(ev_cnt == n0 && !reconfig, "R10", "crc over corrected data",
          {32'(ev_cnt), 32'(reconfig)}, {32'(n0), 32'd0});

      // R5: detect only
      mode = 2'd0;
      flip(4, 2 * DW + 7);
      wait_ev(k, g, w, b);
      chk(k == 1 && g == 4 && w == 2 && b == 7, "R5", "detect event",
          {16'(k), 16'(g), 16'(w), 16'(b)}, {16'd1, 16'd4, 16'd2, 16'd7});
      wait_halted("R5");
      chk(mem[4][2] == (clean[4][2] ^ (32'd1 << 7)), "R5", "no repair written",
          64'(mem[4][2]), 64'(clean[4][2] ^ (32'd1 << 7)));
      poke(4, 2, clean[4][2]);

      // same-window case: repair in last frame and CRC mismatch in one pass
      mode = 2'd2;
      golden = ~pass_crc();
      flip(F1, 0);
      resume_chk(4, "R9");
      wait_ev(k, g, w, b);
      chk(k == 0 && g == F1 && w == 0 && b == 0, "R10", "repair before crc",
          {16'(k), 16'(g), 16'(w), 16'(b)}, {16'd0, 16'(F1), 32'd0});
      wait_ev(k, g, w, b);
      golden = pass_crc();
      chk(k == 3 && g == F1, "R10", "crc event after repair",
          {32'(k), 32'(g)}, {32'd3, 32'(F1)});

      // R8: double-bit frame
      poke(3, 0, clean[3][0] ^ 32'h0000_0002);
      poke(3, 3, clean[3][3] ^ 32'h4000_0000);
      wait_ev(k, g, w, b);
      chk(k == 2 && g == 3 && w == 0 && b == 0, "R8", "multi event",
          {16'(k), 16'(g), 16'(w), 16'(b)}, {16'd2, 16'd3, 32'd0});
      wait_halted("R8");
      chk(mem[3][0] != clean[3][0] && mem[3][3] != clean[3][3], "R8", "no write on multi",
          64'(mem[3][0]), 64'(clean[3][0] ^ 32'h2));
      poke(3, 0, clean[3][0]);
      poke(3, 3, clean[3][3]);

      // R2: parity bit flipped alone is uncorrectable
      poke(F0, WORDS, clean[F0][WORDS] ^ 32'h8000_0000);
      resume_chk(3, "R9");
      wait_ev(k, g, w, b);
      chk(k == 2 && g == F0, "R2", "parity-only mismatch", {32'(k), 32'(g)}, {32'd2, 32'(F0)});
      wait_halted("R8");
      poke(F0, WORDS, clean[F0][WORDS]);
      resume_chk(F0, "R9");
      repeat (60) @(negedge clk);
      chk(!halted && !reconfig, "R9", "running after final resume",
          {32'(halted), 32'(reconfig)}, 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule